// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM from power-on to a usable state. After a start pulse it holds the clock enable low for a programmable settling time. It then raises the clock enable and issues the fixed command series the memory needs before normal use: precharge-all, an extended mode load that turns on the memory's DLL, and a mode load that resets the DLL. After a DLL lock wait it issues a second precharge-all, a programmable number of auto-refresh commands and a final mode load without the DLL reset. It then raises a done flag that holds until the next reset.

All intervals are static inputs counted in clock cycles. Each command lasts one cycle. NOP fills every other cycle. The command, bank and address outputs are registered and go straight to a memory PHY.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is held, and afterwards until a start pulse is sampled, cke is 0, done is 0 and the command pins {cs_n,ras_n,cas_n,we_n} carry NOP = 4'b0111.
- R2: If start is sampled at clock edge E, cke stays 0 for the following max(stab_cycles,1) cycles. It then goes high for one NOP cycle, and the first command appears in the next cycle. Once high, cke stays high until reset.
- R3: The commands come in this fixed order: precharge-all, extended mode load, mode load with DLL reset, precharge-all, the auto-refresh commands, final mode load.
- R4: Command encodings on {cs_n,ras_n,cas_n,we_n} are NOP 0111, precharge-all 0010, auto-refresh 0001 and mode load 0000. A precharge-all drives addr with only bit 10 set. An auto-refresh drives bank and addr as 0.
- R5: The extended mode load drives bank = 2'b01 and addr = ext_mode_word. The DLL-reset mode load drives bank = 2'b00 and addr = mode_word with bit 8 set. The final mode load drives bank = 2'b00 and addr = mode_word with bit 8 cleared.
- R6: After a precharge-all, exactly max(prech_gap,1) NOP cycles pass before the next command. After an auto-refresh the count is max(refresh_gap,1), and after the extended mode load it is max(mode_gap,1).
- R7: Between the DLL-reset mode load and the second precharge-all, exactly max(mode_gap,1) + max(lock_cycles,1) NOP cycles pass.
- R8: The number of auto-refresh commands issued is max(refresh_num,1).
- R9: done rises max(mode_gap,1)+1 cycles after the final mode load. It then stays high, with NOP on the command pins, until reset.
- R10: A start pulse while the sequence is running, or after done, changes neither the command stream nor the timing nor the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when the block is idle |
| stab_cycles | input | CW | Settling time with cke low, in cycles |
| prech_gap | input | CW | Minimum cycles after a precharge-all |
| mode_gap | input | CW | Minimum cycles after a mode load |
| refresh_gap | input | CW | Minimum cycles after an auto-refresh |
| lock_cycles | input | CW | DLL lock wait after the DLL-reset load |
| refresh_num | input | RW | Number of auto-refresh commands |
| ext_mode_word | input | AW | Extended mode register value (DLL enable) |
| mode_word | input | AW | Mode register value, bit 8 is forced by the block |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bank | output | 2 | Bank address (mode register select) |
| addr | output | AW | Address bus |
| done | output | 1 | Initialization complete, sticky until reset |

## Verification
Every output is one register away from the sequencing state. The bench counts cycles from the edge that samples start and samples once per cycle on the falling edge. It logs each non-NOP command with its cycle index, plus the first cycles in which cke and done are high. From the interval inputs and R2, R6, R7 and R9, the bench works out the exact index each command, the cke rise and the done rise must land on, and compares them with the log. Zero-valued intervals, the refresh-count boundary and stray start pulses are checked against the same arithmetic.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

  // Pin pattern {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } cmd_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_STAB,
    ST_CKEUP,
    ST_PALL1,
    ST_W_RP1,
    ST_EMR,
    ST_W_MRD1,
    ST_MRDLL,
    ST_W_MRD2,
    ST_W_LOCK,
    ST_PALL2,
    ST_W_RP2,
    ST_REF,
    ST_W_RFC,
    ST_MRFIN,
    ST_W_MRD3,
    ST_DONE
  } step_e;

endpackage

// File: rtl/ddr_pwrup_timer.sv
module ddr_pwrup_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] value,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  // A loaded value N yields N cycles in the waiting state; 0 acts as 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (value == '0) ? '0 : value - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_pwrup_cmdenc.sv
module ddr_pwrup_cmdenc
  import ddr_pwrup_pkg::*;
#(
  parameter int AW          = 13,
  parameter int DLL_RST_BIT = 8,
  parameter int A10_BIT     = 10
) (
  input  step_e         step,
  input  logic [AW-1:0] ext_mode_word,
  input  logic [AW-1:0] mode_word,
  output cmd_e          cmd,
  output logic [1:0]    bank,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] DLL_MASK = AW'(1) << DLL_RST_BIT;
  localparam logic [AW-1:0] ALL_MASK = AW'(1) << A10_BIT;

  always_comb begin
    cmd  = CMD_NOP;
    bank = 2'b00;
    addr = '0;
    case (step)
      ST_PALL1, ST_PALL2: begin
        cmd  = CMD_PALL;
        addr = ALL_MASK;
      end
      ST_EMR: begin
        cmd  = CMD_MRS;
        bank = 2'b01;
        addr = ext_mode_word;
      end
      ST_MRDLL: begin
        cmd  = CMD_MRS;
        addr = mode_word | DLL_MASK;
      end
      ST_MRFIN: begin
        cmd  = CMD_MRS;
        addr = mode_word & ~DLL_MASK;
      end
      ST_REF: cmd = CMD_REF;
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_pwrup_pkg::*;
#(
  parameter int CW          = 16,
  parameter int RW          = 4,
  parameter int AW          = 13,
  parameter int DLL_RST_BIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] stab_cycles,
  input  logic [CW-1:0] prech_gap,
  input  logic [CW-1:0] mode_gap,
  input  logic [CW-1:0] refresh_gap,
  input  logic [CW-1:0] lock_cycles,
  input  logic [RW-1:0] refresh_num,
  input  logic [AW-1:0] ext_mode_word,
  input  logic [AW-1:0] mode_word,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [1:0]    bank,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam int A10_BIT = 10;

  step_e         step_q, step_d;
  logic          t_zero, t_load;
  logic [CW-1:0] t_value;
  logic [RW-1:0] ref_cnt_q;
  logic [RW-1:0] ref_goal;
  cmd_e          enc_cmd;
  logic [1:0]    enc_bank;
  logic [AW-1:0] enc_addr;

  assign ref_goal = (refresh_num == '0) ? RW'(1) : refresh_num;

  function automatic logic is_wait(step_e s);
    return s inside {ST_STAB, ST_W_RP1, ST_W_MRD1, ST_W_MRD2, ST_W_LOCK,
                     ST_W_RP2, ST_W_RFC, ST_W_MRD3};
  endfunction

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_IDLE:   if (start) step_d = ST_STAB;
      ST_STAB:   if (t_zero) step_d = ST_CKEUP;
      ST_CKEUP:  step_d = ST_PALL1;
      ST_PALL1:  step_d = ST_W_RP1;
      ST_W_RP1:  if (t_zero) step_d = ST_EMR;
      ST_EMR:    step_d = ST_W_MRD1;
      ST_W_MRD1: if (t_zero) step_d = ST_MRDLL;
      ST_MRDLL:  step_d = ST_W_MRD2;
      ST_W_MRD2: if (t_zero) step_d = ST_W_LOCK;
      ST_W_LOCK: if (t_zero) step_d = ST_PALL2;
      ST_PALL2:  step_d = ST_W_RP2;
      ST_W_RP2:  if (t_zero) step_d = ST_REF;
      ST_REF:    step_d = ST_W_RFC;
      ST_W_RFC:  if (t_zero) step_d = (ref_cnt_q >= ref_goal) ? ST_MRFIN : ST_REF;
      ST_MRFIN:  step_d = ST_W_MRD3;
      ST_W_MRD3: if (t_zero) step_d = ST_DONE;
      ST_DONE:   step_d = ST_DONE;
      default:   step_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (step_d)
      ST_STAB:                        t_value = stab_cycles;
      ST_W_RP1, ST_W_RP2:             t_value = prech_gap;
      ST_W_LOCK:                      t_value = lock_cycles;
      ST_W_RFC:                       t_value = refresh_gap;
      default:                        t_value = mode_gap;
    endcase
  end

  assign t_load = (step_d != step_q) && is_wait(step_d);

  ddr_pwrup_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (t_load),
    .value (t_value),
    .zero  (t_zero)
  );

  ddr_pwrup_cmdenc #(.AW(AW), .DLL_RST_BIT(DLL_RST_BIT), .A10_BIT(A10_BIT)) u_enc (
    .step          (step_d),
    .ext_mode_word (ext_mode_word),
    .mode_word     (mode_word),
    .cmd           (enc_cmd),
    .bank          (enc_bank),
    .addr          (enc_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= ST_IDLE;
      ref_cnt_q <= '0;
    end else begin
      step_q <= step_d;
      if (step_q == ST_REF) ref_cnt_q <= ref_cnt_q + RW'(1);
    end
  end

  // Registered outputs, aligned with the state just entered
  always_ff @(posedge clk) begin
    if (rst) begin
      cke                        <= 1'b0;
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      bank                       <= 2'b00;
      addr                       <= '0;
      done                       <= 1'b0;
    end else begin
      cke                        <= !(step_d inside {ST_IDLE, ST_STAB});
      {cs_n, ras_n, cas_n, we_n} <= enc_cmd;
      bank                       <= enc_bank;
      addr                       <= enc_addr;
      done                       <= (step_d == ST_DONE);
    end
  end

  logic [3:0] pins;
  assign pins = {cs_n, ras_n, cas_n, we_n};

  assert_cmd_needs_cke_R2: assert property (@(posedge clk) disable iff (rst)
    (pins != CMD_NOP) |-> (cke && $past(cke)));

  assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  assert_single_cycle_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    (pins != CMD_NOP) |=> (pins == CMD_NOP));

  assert_pall_a10_R4: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_PALL) |-> addr[A10_BIT]);

  assert_mode_bank_R5: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_MRS) |-> (bank[1] == 1'b0));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (pins == CMD_NOP && cke));

endmodule

// File: tb/tb_ddr_pwrup_seq.sv
module tb_ddr_pwrup_seq;
  localparam int CW = 16;
  localparam int RW = 4;
  localparam int AW = 13;
  localparam int NOP = 4'b0111, PALL = 4'b0010, REFC = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, start, cke, cs_n, ras_n, cas_n, we_n, done;
  logic [CW-1:0] stab_cycles, prech_gap, mode_gap, refresh_gap, lock_cycles;
  logic [RW-1:0] refresh_num;
  logic [AW-1:0] ext_mode_word, mode_word, addr;
  logic [1:0]    bank;

  ddr_pwrup_seq #(.CW(CW), .RW(RW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .stab_cycles(stab_cycles),
    .prech_gap(prech_gap), .mode_gap(mode_gap), .refresh_gap(refresh_gap),
    .lock_cycles(lock_cycles), .refresh_num(refresh_num),
    .ext_mode_word(ext_mode_word), .mode_word(mode_word), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .bank(bank),
    .addr(addr), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;

  int ev_cmd[64], ev_ba[64], ev_addr[64], ev_idx[64];
  int n_ev, cke_rise, done_rise, cke_fall, late_cmd;
  int ex_cmd[64], ex_ba[64], ex_addr[64], ex_idx[64];
  int n_ex;

  function automatic int m1(int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic int pins();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cfg(int s, int rp, int mrd, int lk, int rfc, int nr, int emr, int mr);
    stab_cycles   = CW'(s);
    prech_gap     = CW'(rp);
    mode_gap      = CW'(mrd);
    lock_cycles   = CW'(lk);
    refresh_gap   = CW'(rfc);
    refresh_num   = RW'(nr);
    ext_mode_word = AW'(emr);
    mode_word     = AW'(mr);
  endtask

  // Pulses start, then logs samples 0..len-1 (sample 0 follows the capturing edge)
  task automatic record(int len, int stray_at);
    n_ev = 0; cke_rise = -1; done_rise = -1; cke_fall = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (pins() != NOP && n_ev < 64) begin
        ev_cmd[n_ev] = pins(); ev_ba[n_ev] = int'(bank);
        ev_addr[n_ev] = int'(addr); ev_idx[n_ev] = k;
        n_ev++;
      end
      if (cke && cke_rise < 0) cke_rise = k;
      if (!cke && cke_rise >= 0) cke_fall++;
      if (done && done_rise < 0) done_rise = k;
      start = (k == stray_at);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic add_ex(int c, int b, int a, int i);
    ex_cmd[n_ex] = c; ex_ba[n_ex] = b; ex_addr[n_ex] = a; ex_idx[n_ex] = i;
    n_ex++;
  endtask

  task automatic compare(int s, int rp, int mrd, int lk, int rfc, int nr, int emr, int mr);
    int t;
    n_ex = 0;
    t = m1(s) + 1;
    add_ex(PALL, 0, 1 << 10, t);                        t += 1 + m1(rp);
    add_ex(MRS, 1, emr, t);                             t += 1 + m1(mrd);
    add_ex(MRS, 0, (mr | 256) & 8191, t);               t += 1 + m1(mrd) + m1(lk);
    add_ex(PALL, 0, 1 << 10, t);                        t += 1 + m1(rp);
    for (int r = 0; r < m1(nr); r++) begin
      add_ex(REFC, 0, 0, t);                            t += 1 + m1(rfc);
    end
    add_ex(MRS, 0, mr & ~256 & 8191, t);                t += 1 + m1(mrd);
    chk(cke_rise == m1(s), "R2", "cke rise cycle", cke_rise, m1(s));
    chk(cke_fall == 0, "R2", "cke low after rise", cke_fall, 0);
    chk(n_ev == n_ex, "R3/R8", "command count", n_ev, n_ex);
    for (int i = 0; i < n_ex && i < n_ev; i++) begin
      chk(ev_cmd[i] == ex_cmd[i], "R3 R4", $sformatf("cmd %0d code", i), ev_cmd[i], ex_cmd[i]);
      chk(ev_ba[i] == ex_ba[i], "R5", $sformatf("cmd %0d bank", i), ev_ba[i], ex_ba[i]);
      chk(ev_addr[i] == ex_addr[i], "R4 R5", $sformatf("cmd %0d addr", i), ev_addr[i], ex_addr[i]);
      chk(ev_idx[i] == ex_idx[i], "R6 R7", $sformatf("cmd %0d cycle", i), ev_idx[i], ex_idx[i]);
    end
    chk(done_rise == t, "R9", "done rise cycle", done_rise, t);
    chk(done === 1'b1, "R9", "done still high", int'(done), 1);
  endtask

  // R1: reset state and idle without start
  task automatic test_idle();
    int bad = 0;
    do_reset();
    set_cfg(3, 1, 1, 1, 1, 1, 0, 0);
    for (int k = 0; k < 30; k++) begin
      if (cke !== 1'b0 || done !== 1'b0 || pins() != NOP) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R1", "idle cycles off spec", bad, 0);
  endtask

  // R2..R9: typical configuration
  task automatic test_typical();
    do_reset();
    set_cfg(20, 2, 2, 10, 5, 2, 'h0002, 'h0032);
    record(200, -1);
    compare(20, 2, 2, 10, 5, 2, 'h0002, 'h0032);
  endtask

  // R10: stray start mid-run, different intervals, more refreshes
  task automatic test_stray_start();
    do_reset();
    set_cfg(5, 3, 1, 4, 7, 4, 'h0040, 'h1133);
    record(200, 15);
    compare(5, 3, 1, 4, 7, 4, 'h0040, 'h1133);
  endtask

  // R6 R7 R8: zero-valued intervals and zero refresh count act as one
  task automatic test_zero();
    do_reset();
    set_cfg(0, 0, 0, 0, 0, 0, 'h1fff, 'h0100);
    record(100, -1);
    compare(0, 0, 0, 0, 0, 0, 'h1fff, 'h0100);
  endtask

  // R9 R10: start after done is ignored; reset clears done
  task automatic test_after_done();
    int extra = 0;
    int lowd = 0;
    do_reset();
    set_cfg(2, 1, 1, 1, 1, 1, 0, 0);
    record(60, -1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (pins() != NOP) extra++;
      if (done !== 1'b1 || cke !== 1'b1) lowd++;
      @(negedge clk);
    end
    chk(extra == 0, "R10", "commands after done", extra, 0);
    chk(lowd == 0, "R9", "done/cke dropped", lowd, 0);
    do_reset();
    chk(done === 1'b0 && cke === 1'b0, "R1", "done|cke after reset", int'(done) + int'(cke), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    set_cfg(1, 1, 1, 1, 1, 1, 0, 0);
    test_idle();
    test_typical();
    test_stray_start();
    test_zero();
    test_after_done();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule